// File: doc/BRIEF.md
# Floppy Controller Host Register Interface

This block sits between a host processor and the internals of a floppy disk controller. The host reaches five registers through a chip select (active low), a read/write strobe, a two-bit register address and an 8-bit bidirectional data bus. On the disk side, the block swaps whole bytes with a serial shift register over two strobes: one hands over a newly assembled byte, and the other asks for the next byte to serialise. A single data register serves both transfer directions. The command sequencer is not part of this block. It appears only as a transfer-direction level, a command-complete pulse and a force-interrupt pulse.

A data-request flag tracks whether the data register is waiting for host service. During disk reads it means the register is full. During disk writes it means the register is empty. A lost-data flag records a byte that was overwritten before the host read it, or a write request that arrived with no host byte supplied. An interrupt request is raised when a command finishes or is forced. It is dropped when the host reads status or issues a new command.

Top module: `fdc_host_regs`

## Requirements
- R1: The data bus is driven only while `cs_n`=0 and `rw`=1. In every other case it is high impedance.
- R2: A host read with `rw`=1 returns, by address: 0 = status, 1 = track, 2 = sector, 3 = data.
- R3: A host write with `rw`=0 loads, by address: 0 = command, 1 = track, 2 = sector, 3 = data. A command write places the byte on `cmd_q` and pulses `cmd_stb` for one cycle.
- R4: In read mode (`xfer_wr`=0), `rd_stb` loads `rd_byte` into the data register and sets DRQ. A host read of the data register clears DRQ.
- R5: In read mode, `rd_stb` arriving while DRQ is set (and the data register is not being read in the same cycle) sets lost-data. The newer byte replaces the older one.
- R6: In write mode (`xfer_wr`=1), `wr_req` with DRQ clear moves the data register to `wr_byte` on the next cycle and sets DRQ. A host data write clears DRQ.
- R7: In write mode, `wr_req` while DRQ is still set sends 0x00 to `wr_byte` and sets lost-data.
- R8: The status byte is bit0 busy, bit1 DRQ, bit2 lost-data, and bits 7..3 zero. The `drq` pin equals status bit 1.
- R9: `cmd_done` or `force_irq` sets INTRQ. A host status read or a command write clears it.
- R10: A command write sets busy and clears DRQ, lost-data and INTRQ. `cmd_done` clears busy.
- R11: `mr_n`=0 clears all registers, DRQ, INTRQ, busy and lost-data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| mr_n | input | 1 | Master reset, active low, asynchronous |
| cs_n | input | 1 | Chip select, active low |
| rw | input | 1 | 1 = host read, 0 = host write |
| addr | input | 2 | Register select |
| data | inout | 8 | Host data bus, tristate |
| xfer_wr | input | 1 | Current transfer direction, 1 = disk write |
| rd_stb | input | 1 | Assembled byte ready from the shift register |
| rd_byte | input | 8 | Assembled byte |
| wr_req | input | 1 | Shift register wants the next byte |
| wr_byte | output | 8 | Byte handed to the shift register |
| cmd_done | input | 1 | Command-complete pulse from the sequencer |
| force_irq | input | 1 | Force-interrupt condition pulse |
| cmd_q | output | 8 | Last command written |
| cmd_stb | output | 1 | One-cycle pulse after a command write |
| drq | output | 1 | Data request |
| intrq | output | 1 | Interrupt request |

## Verification
The assertions assume that each host access holds `cs_n` low for exactly one clock, so that one access has one side effect. They also assume that `xfer_wr` is held steady for the whole command, and that the disk strobes, `cmd_done` and `force_irq` are single-cycle pulses. The bench drives every access and pulse for exactly one cycle, starting at the falling edge. It changes `xfer_wr` only before a command write, and never overlaps a command write with a sequencer pulse. The properties are written to exclude the colliding cases they do not describe.

// File: rtl/fdc_host_regs.sv
module fdc_host_regs #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         mr_n,
  input  logic         cs_n,
  input  logic         rw,
  input  logic [1:0]   addr,
  inout  wire  [W-1:0] data,
  input  logic         xfer_wr,
  input  logic         rd_stb,
  input  logic [W-1:0] rd_byte,
  input  logic         wr_req,
  output logic [W-1:0] wr_byte,
  input  logic         cmd_done,
  input  logic         force_irq,
  output logic [W-1:0] cmd_q,
  output logic         cmd_stb,
  output logic         drq,
  output logic         intrq
);
  localparam logic [1:0] A_CTL = 2'd0, A_TRK = 2'd1, A_SEC = 2'd2, A_DAT = 2'd3;

  logic [W-1:0] trk_q, sec_q, dat_q, rd_mux, status;
  logic         busy, lost;

  wire host_rd  = !cs_n && rw;
  wire host_wr  = !cs_n && !rw;
  wire cmd_wr   = host_wr && addr == A_CTL;
  wire stat_rd  = host_rd && addr == A_CTL;
  wire dat_rd   = host_rd && addr == A_DAT;
  wire dat_wr   = host_wr && addr == A_DAT;
  wire disk_in  = rd_stb && !xfer_wr;
  wire disk_out = wr_req && xfer_wr;

  assign status = {{(W-3){1'b0}}, lost, drq, busy};

  always_comb
    case (addr)
      A_CTL:   rd_mux = status;
      A_TRK:   rd_mux = trk_q;
      A_SEC:   rd_mux = sec_q;
      default: rd_mux = dat_q;
    endcase

  assign data = host_rd ? rd_mux : {W{1'bz}};

  always_ff @(posedge clk or negedge mr_n) begin
    if (!mr_n) begin
      trk_q <= '0; sec_q <= '0; dat_q <= '0; cmd_q <= '0; wr_byte <= '0;
      cmd_stb <= 1'b0; drq <= 1'b0; intrq <= 1'b0; busy <= 1'b0; lost <= 1'b0;
    end else begin
      cmd_stb <= cmd_wr;
      if (host_wr && addr == A_TRK) trk_q <= data;
      if (host_wr && addr == A_SEC) sec_q <= data;
      if (cmd_wr) begin
        cmd_q <= data;
        busy  <= 1'b1;
        drq   <= 1'b0;
        lost  <= 1'b0;
        intrq <= 1'b0;
      end else begin
        if (cmd_done) busy <= 1'b0;
        if (cmd_done || force_irq) intrq <= 1'b1;
        else if (stat_rd)          intrq <= 1'b0;
        if (!xfer_wr) begin
          if (dat_wr) dat_q <= data;
          if (disk_in) begin
            dat_q <= rd_byte;
            drq   <= 1'b1;
            if (drq && !dat_rd) lost <= 1'b1;
          end else if (dat_rd) begin
            drq <= 1'b0;
          end
        end else begin
          if (dat_wr) dat_q <= data;
          if (disk_out) begin
            drq <= 1'b1;
            if (dat_wr)   wr_byte <= data;
            else if (drq) begin wr_byte <= '0; lost <= 1'b1; end
            else          wr_byte <= dat_q;
          end else if (dat_wr) begin
            drq <= 1'b0;
          end
        end
      end
    end
  end

  p_rd_set_r4: assert property (@(posedge clk) disable iff (!mr_n)
    disk_in && !cmd_wr |=> drq && dat_q == $past(rd_byte));
  p_rd_clr_r4: assert property (@(posedge clk) disable iff (!mr_n)
    dat_rd && !xfer_wr && !rd_stb && !cmd_wr |=> !drq);
  p_rd_lost_r5: assert property (@(posedge clk) disable iff (!mr_n)
    disk_in && drq && !dat_rd && !cmd_wr |=> lost);
  p_wr_move_r6: assert property (@(posedge clk) disable iff (!mr_n)
    disk_out && !drq && !dat_wr && !cmd_wr |=> drq && wr_byte == $past(dat_q));
  p_wr_clr_r6: assert property (@(posedge clk) disable iff (!mr_n)
    dat_wr && xfer_wr && !wr_req && !cmd_wr |=> !drq);
  p_underrun_r7: assert property (@(posedge clk) disable iff (!mr_n)
    disk_out && drq && !dat_wr && !cmd_wr |=> wr_byte == '0 && lost);
  p_irq_set_r9: assert property (@(posedge clk) disable iff (!mr_n)
    (cmd_done || force_irq) && !cmd_wr |=> intrq);
  p_irq_clr_r9: assert property (@(posedge clk) disable iff (!mr_n)
    stat_rd && !cmd_done && !force_irq |=> !intrq);
  p_cmd_r10: assert property (@(posedge clk) disable iff (!mr_n)
    cmd_wr |=> busy && !drq && !lost && !intrq && cmd_stb);
  p_done_r10: assert property (@(posedge clk) disable iff (!mr_n)
    cmd_done && !cmd_wr |=> !busy);
endmodule

// File: tb/test_fdc_host_regs.sv
module test_fdc_host_regs;
  logic clk = 0, mr_n = 0, cs_n = 1, rw = 1, xfer_wr = 0;
  logic [1:0] addr = 0;
  logic rd_stb = 0, wr_req = 0, cmd_done = 0, force_irq = 0;
  logic [7:0] rd_byte = 0, drv = 0;
  logic drv_en = 0;
  wire  [7:0] data;
  logic [7:0] wr_byte, cmd_q;
  logic cmd_stb, drq, intrq;
  int total = 0, bad = 0;

  assign data = drv_en ? drv : 8'bz;
  always #2.5 clk = ~clk;

  fdc_host_regs i_fdc_host_regs (.clk, .mr_n, .cs_n, .rw, .addr, .data, .xfer_wr,
    .rd_stb, .rd_byte, .wr_req, .wr_byte, .cmd_done, .force_irq, .cmd_q,
    .cmd_stb, .drq, .intrq);

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic hwr(logic [1:0] a, logic [7:0] d);
    @(negedge clk); cs_n = 0; rw = 0; addr = a; drv = d; drv_en = 1;
    @(negedge clk); cs_n = 1; rw = 1; drv_en = 0;
  endtask

  task automatic hrd(logic [1:0] a, output logic [7:0] d);
    @(negedge clk); cs_n = 0; rw = 1; addr = a;
    #1 d = data;
    @(negedge clk); cs_n = 1;
  endtask

  task automatic pulse_rd(logic [7:0] b);
    @(negedge clk); rd_stb = 1; rd_byte = b;
    @(negedge clk); rd_stb = 0;
  endtask

  task automatic pulse_wr();
    @(negedge clk); wr_req = 1;
    @(negedge clk); wr_req = 0;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    chk("R11 drq", {7'b0, drq}, 8'h00);
    chk("R11 intrq", {7'b0, intrq}, 8'h00);
    chk("R11 cmd", cmd_q, 8'h00);
    chk("R1 idle z", data, 8'hzz);
    hrd(2'd0, v); chk("R11 status", v, 8'h00);
    hrd(2'd1, v); chk("R11 track", v, 8'h00);
  endtask

  task automatic t_regs();
    logic [7:0] v;
    hwr(2'd1, 8'h4C); hwr(2'd2, 8'h09);
    hrd(2'd1, v); chk("R2 R3 track", v, 8'h4C);
    hrd(2'd2, v); chk("R2 R3 sector", v, 8'h09);
    @(negedge clk); cs_n = 0; rw = 0; addr = 2'd1;
    #1 chk("R1 z on write", data, 8'hzz);
    cs_n = 1; rw = 1; #1 chk("R1 z deselected", data, 8'hzz);
  endtask

  task automatic t_read_flow();
    logic [7:0] v;
    xfer_wr = 0;
    @(negedge clk); cs_n = 0; rw = 0; addr = 0; drv = 8'h80; drv_en = 1;
    @(negedge clk); cs_n = 1; rw = 1; drv_en = 0;
    chk("R3 cmd_stb", {7'b0, cmd_stb}, 8'h01);
    chk("R3 cmd_q", cmd_q, 8'h80);
    pulse_rd(8'hA5);
    chk("R4 drq set", {7'b0, drq}, 8'h01);
    hrd(2'd0, v); chk("R8 status rd", v, 8'h03);
    hwr(2'd3, 8'h11);
    chk("R4 host write ignored for drq", {7'b0, drq}, 8'h01);
    hrd(2'd3, v); chk("R4 data", v, 8'h11);
    chk("R4 drq clr", {7'b0, drq}, 8'h00);
    pulse_rd(8'h33); pulse_rd(8'h44);
    hrd(2'd0, v); chk("R5 lost", v, 8'h07);
    hrd(2'd3, v); chk("R5 newer byte", v, 8'h44);
  endtask

  task automatic t_write_flow();
    logic [7:0] v;
    xfer_wr = 1;
    hwr(2'd0, 8'hA0);
    hrd(2'd0, v); chk("R10 cmd clears", v, 8'h01);
    hwr(2'd3, 8'h5A);
    pulse_wr();
    chk("R6 byte out", wr_byte, 8'h5A);
    hrd(2'd0, v); chk("R6 R8 drq set", v, 8'h03);
    pulse_wr();
    chk("R7 zero byte", wr_byte, 8'h00);
    hrd(2'd0, v); chk("R7 lost", v, 8'h07);
    hwr(2'd3, 8'h77);
    hrd(2'd0, v); chk("R6 drq clr", v, 8'h05);
    pulse_wr();
    chk("R6 next byte", wr_byte, 8'h77);
  endtask

  task automatic t_irq();
    logic [7:0] v;
    @(negedge clk); cmd_done = 1;
    @(negedge clk); cmd_done = 0;
    chk("R9 intrq set", {7'b0, intrq}, 8'h01);
    hrd(2'd0, v); chk("R10 busy clr", v[0], 1'b0);
    chk("R9 status clears", {7'b0, intrq}, 8'h00);
    @(negedge clk); force_irq = 1;
    @(negedge clk); force_irq = 0;
    chk("R9 force", {7'b0, intrq}, 8'h01);
    hwr(2'd0, 8'hD0);
    chk("R9 cmd clears", {7'b0, intrq}, 8'h00);
    hrd(2'd0, v); chk("R10 busy set", v, 8'h01);
  endtask

  task automatic t_mreset();
    logic [7:0] v;
    pulse_rd(8'h99);
    @(negedge clk); mr_n = 0;
    @(negedge clk); mr_n = 1;
    hrd(2'd0, v); chk("R11 status", v, 8'h00);
    hrd(2'd1, v); chk("R11 track clr", v, 8'h00);
    hrd(2'd3, v); chk("R11 data clr", v, 8'h00);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        mr_n = 1;
        t_reset(); t_regs(); t_read_flow(); t_write_flow(); t_irq(); t_mreset();
      end
      begin
        repeat (5000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog act=running exp=finished");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule